// File: doc/BRIEF.md
# Conversion Rate and One-Shot Scheduler

This block decides when a periodic measurement engine begins a conversion. A base timer tick arrives as a single-cycle strobe. It is divided by a power of two that a small rate register selects. In run mode the block issues a conversion-start pulse each time the selected number of ticks has passed while the engine is idle. In standby it issues nothing on its own. A single-cycle one-shot strobe then starts exactly one conversion, and the block stays in standby afterwards.

The engine reports completion with a one-cycle done strobe, which releases the busy flag. The rate register holds a 3-bit code in the low bits of an 8-bit value. A larger code makes conversions more frequent: code 0 waits 128 ticks and code 7 waits 1 tick. The register reads back with its upper bits at zero. All pins are plain level or strobe signals, and no port carries a data stream, so there is no valid/ready handshake.

Top module: `conv_scheduler`

## Requirements
- R1: After reset the rate code is 7, `rate_rdata_o` reads 0x07, and both `conv_start_o` and `busy_o` are 0.
- R2: A rate write whose bits [7:3] are all zero stores bits [2:0] as the code. From the next cycle `rate_rdata_o` reads {5'b0, code}.
- R3: A rate write with any of bits [7:3] set (values 0x08 to 0xFF) is ignored. The code and the readback keep their previous values, and so does the interval in progress.
- R4: In run mode (`standby_i` = 0), `conv_start_o` pulses after 2^(7-code) base ticks have been counted while not busy. The count restarts from zero after each start, and ticks that arrive while busy are not counted.
- R5: `conv_start_o` is high for one cycle, in the cycle after the tick or strobe that triggers it, and `busy_o` rises in that same cycle. `busy_o` falls in the cycle after `conv_done_i` is seen while busy. A done strobe while idle has no effect.
- R6: In standby, no start is issued, however many ticks arrive.
- R7: A one-shot strobe in standby while not busy gives exactly one start in the next cycle. After the done strobe the block stays idle in standby.
- R8: A one-shot strobe in run mode, or while busy, issues no start and does not disturb the interval count.
- R9: An accepted rate write, even one that repeats the current code, restarts the interval count from zero.
- R10: Entering standby clears the interval count. On return to run, the first start needs a full interval of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base timer tick strobe |
| rate_wr_i | input | 1 | Rate register write strobe |
| rate_wdata_i | input | 8 | Rate register write value |
| rate_rdata_o | output | 8 | Rate register readback |
| standby_i | input | 1 | 0 = run, 1 = standby |
| oneshot_wr_i | input | 1 | One-shot command strobe |
| conv_done_i | input | 1 | Conversion finished strobe from the engine |
| conv_start_o | output | 1 | Conversion start pulse |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench measures the exact tick count to a start at the slowest, fastest and middle codes. An off-by-one divider, or an inverted code-to-ratio mapping, would show up there as a wrong count. It feeds ticks during a busy period and issues one-shot strobes in run mode and while busy; a design that counted through busy, or that honoured those strobes, would start early or twice. Reserved writes, a rewrite of the same code, and a standby round trip in mid-interval are all checked against the full interval that follows. A register that accepted reserved values, or a counter that did not restart, would give a short count.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int CODE_W_DEF = 3;
  localparam int REG_W_DEF  = 8;

  // Number of base ticks per conversion for a code: larger code, shorter wait.
  function automatic int unsigned ticks_for_code(input int unsigned code, input int unsigned code_w);
    int unsigned top;
    top = (1 << code_w) - 1;
    return 1 << (top - code);
  endfunction
endpackage

// File: rtl/rate_reg.sv
module rate_reg #(
  parameter int CODE_W     = 3,
  parameter int REG_W      = 8,
  parameter int RESET_CODE = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              accepted_o
);
  localparam int PAD_W = REG_W - CODE_W;

  logic reserved;
  assign reserved   = |wdata_i[REG_W-1:CODE_W];
  assign accepted_o = wr_i && !reserved;

  always_ff @(posedge clk) begin
    if (!rst_n)          code_o <= CODE_W'(RESET_CODE);
    else if (accepted_o) code_o <= wdata_i[CODE_W-1:0];
  end

  assign rdata_o = {{PAD_W{1'b0}}, code_o};

  assert_reserved_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && reserved) |=> $stable(code_o));
  assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !reserved) |=> (code_o == $past(wdata_i[CODE_W-1:0])));
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[REG_W-1:CODE_W] == '0);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              expire_o
);
  localparam int MAX_SH = (1 << CODE_W) - 1;
  localparam int CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limit;
  logic             last;

  assign limit    = (CNT_W+1)'(1) << (CNT_W'(MAX_SH) - CNT_W'(code_i));
  assign last     = ({1'b0, cnt} == (limit - 1'b1));
  assign expire_o = tick_i && run_i && !hold_i && !clear_i && last;

  always_ff @(posedge clk) begin
    if (!rst_n)                            cnt <= '0;
    else if (!run_i || clear_i || expire_o) cnt <= '0;
    else if (tick_i && !hold_i)             cnt <= cnt + 1'b1;
  end

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} < limit) || $past(clear_i));
  assert_standby_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0));
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && hold_i && !clear_i) |=> $stable(cnt));
endmodule

// File: rtl/start_ctrl.sv
module start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic oneshot_i,
  input  logic standby_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o
);
  logic fire;
  assign fire = !busy_o && (expire_i || (oneshot_i && standby_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      start_o <= fire;
      if (fire)                busy_o <= 1'b1;
      else if (busy_o && done_i) busy_o <= 1'b0;
    end
  end

  assert_start_with_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_i));
  assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !start_o);
  assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i && !oneshot_i) |=> !start_o);
endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler
  import sched_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int REG_W  = REG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             rate_wr_i,
  input  logic [REG_W-1:0] rate_wdata_i,
  output logic [REG_W-1:0] rate_rdata_o,
  input  logic             standby_i,
  input  logic             oneshot_wr_i,
  input  logic             conv_done_i,
  output logic             conv_start_o,
  output logic             busy_o
);
  logic [CODE_W-1:0] code;
  logic              accepted;
  logic              expire;

  rate_reg #(.CODE_W(CODE_W), .REG_W(REG_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .wr_i(rate_wr_i), .wdata_i(rate_wdata_i),
    .code_o(code), .rdata_o(rate_rdata_o), .accepted_o(accepted)
  );

  interval_timer #(.CODE_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(!standby_i),
    .hold_i(busy_o), .clear_i(accepted), .code_i(code), .expire_o(expire)
  );

  start_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .oneshot_i(oneshot_wr_i),
    .standby_i(standby_i), .done_i(conv_done_i),
    .start_o(conv_start_o), .busy_o(busy_o)
  );

  assert_oneshot_run_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_wr_i && !standby_i && !tick_i) |=> !conv_start_o);
endmodule

// File: tb/sim_conv_scheduler.sv
module sim_conv_scheduler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       rate_wr_i = 1'b0;
  logic [7:0] rate_wdata_i = '0;
  logic [7:0] rate_rdata_o;
  logic       standby_i = 1'b0;
  logic       oneshot_wr_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic       conv_start_o;
  logic       busy_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  conv_scheduler u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_wr_i(rate_wr_i),
    .rate_wdata_i(rate_wdata_i), .rate_rdata_o(rate_rdata_o), .standby_i(standby_i),
    .oneshot_wr_i(oneshot_wr_i), .conv_done_i(conv_done_i),
    .conv_start_o(conv_start_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic write_rate(input logic [7:0] v);
    @(negedge clk) begin rate_wr_i = 1'b1; rate_wdata_i = v; end
    @(negedge clk) rate_wr_i = 1'b0;
  endtask

  task automatic measure(output int n, input int max);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      do_tick();
      if (conv_start_o) begin n = i; break; end
    end
  endtask

  task automatic finish_conv(input string req);
    @(negedge clk) conv_done_i = 1'b1;
    @(negedge clk) conv_done_i = 1'b0;
    check(req, busy_o, 0);
  endtask

  function automatic int expect_ticks(input int code);
    return 1 << (7 - code);
  endfunction

  task automatic t_reset();
    check("R1 readback", rate_rdata_o, 8'h07);
    check("R1 start", conv_start_o, 0);
    check("R1 busy", busy_o, 0);
  endtask

  task automatic t_rates();
    int n;
    int codes[4] = '{5, 7, 0, 3};
    foreach (codes[k]) begin
      write_rate(8'(codes[k]));
      check("R2 readback", rate_rdata_o, codes[k]);
      measure(n, 200);
      check("R4 interval", n, expect_ticks(codes[k]));
      check("R5 busy with start", busy_o, 1);
      finish_conv("R5 busy release");
    end
  endtask

  task automatic t_busy();
    int n;
    write_rate(8'h5);
    measure(n, 20);
    check("R4 first", n, 4);
    @(negedge clk);
    check("R5 one pulse", conv_start_o, 0);
    check("R5 busy held", busy_o, 1);
    for (int i = 0; i < 6; i++) begin
      do_tick();
      check("R4 no start busy", conv_start_o, 0);
    end
    finish_conv("R5 done");
    @(negedge clk) conv_done_i = 1'b1;
    @(negedge clk) conv_done_i = 1'b0;
    check("R5 idle done", busy_o + conv_start_o, 0);
    measure(n, 20);
    check("R4 busy ticks not counted", n, 4);
    finish_conv("R5 done2");
  endtask

  task automatic t_reserved();
    int n;
    write_rate(8'h4);
    do_tick(); do_tick();
    write_rate(8'h08);
    check("R3 keep 08", rate_rdata_o, 4);
    write_rate(8'hFF);
    check("R3 keep FF", rate_rdata_o, 4);
    measure(n, 40);
    check("R3 interval undisturbed", n, 6);
    finish_conv("R3 done");
  endtask

  task automatic t_restart();
    int n;
    write_rate(8'h2);
    for (int i = 0; i < 20; i++) do_tick();
    write_rate(8'h2);
    measure(n, 60);
    check("R9 restart", n, 32);
    finish_conv("R9 done");
  endtask

  task automatic t_standby_cycle();
    int n;
    write_rate(8'h4);
    for (int i = 0; i < 5; i++) do_tick();
    @(negedge clk) standby_i = 1'b1;
    for (int i = 0; i < 300; i++) begin
      do_tick();
      if (conv_start_o) check("R6 no periodic start", 1, 0);
    end
    check("R6 standby idle", busy_o, 0);
    @(negedge clk) standby_i = 1'b0;
    measure(n, 40);
    check("R10 full interval", n, 8);
    finish_conv("R10 done");
  endtask

  task automatic t_oneshot();
    @(negedge clk) standby_i = 1'b1;
    @(negedge clk) oneshot_wr_i = 1'b1;
    @(negedge clk) oneshot_wr_i = 1'b0;
    check("R7 start", conv_start_o, 1);
    check("R7 busy", busy_o, 1);
    @(negedge clk) oneshot_wr_i = 1'b1;
    @(negedge clk) oneshot_wr_i = 1'b0;
    check("R8 busy oneshot", conv_start_o, 0);
    finish_conv("R7 done");
    for (int i = 0; i < 20; i++) begin
      do_tick();
      if (conv_start_o || busy_o) check("R7 back to standby", 1, 0);
    end
    check("R7 stays idle", busy_o, 0);
  endtask

  task automatic t_oneshot_run();
    int n;
    @(negedge clk) standby_i = 1'b0;
    write_rate(8'h5);
    do_tick(); do_tick();
    @(negedge clk) oneshot_wr_i = 1'b1;
    @(negedge clk) oneshot_wr_i = 1'b0;
    check("R8 run oneshot", conv_start_o + busy_o, 0);
    measure(n, 20);
    check("R8 count intact", n, 2);
    finish_conv("R8 done");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_busy();
    t_reserved();
    t_restart();
    t_standby_cycle();
    t_oneshot();
    t_oneshot_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule